// File: doc/BRIEF.md
# Segmented Virtual Address Decoder with Fault Reporting

This block takes a 32-bit virtual address together with the current privilege mode, an error-level flag and a read/write flag, and decides how that access is resolved. The address space is split by its top bits into five fixed segments. Two kernel windows are translated directly by removing a fixed base. The low user window is passed through one-to-one while the error-level flag is set. The remaining windows are handed to an external TLB lookup, whose two-bit result code and physical address come back in the same cycle.

Every access is resolved combinationally into a physical address or a fault. A fault comes with a five-bit exception code and a refill indication. On the clock edge where the fault flag is high, three fault registers are updated: the bad-address register, the context register and the entry-high register. The reset values of the context upper field and of the entry-high identifier are parameters, so that the preserved fields carry known contents.

Top module: `seg_xlate_top`

## Requirements
- R1: For an address with bit 31 clear and the error-level flag set, the physical address equals the virtual address, no TLB lookup is requested (tlb_req low) and no fault is raised, whatever the mode.
- R2: For an address with bit 31 clear and the error-level flag clear, tlb_req is high. On a TLB hit (tlb_res 2'b00) the physical address is tlb_pa and no fault is raised.
- R3: In kernel mode, an address in 0x80000000..0x9FFFFFFF translates to the address minus 0x80000000, and an address in 0xA0000000..0xBFFFFFFF translates to the address minus 0xA0000000. In both cases tlb_req is low and tlb_res has no effect.
- R4: The mode encoding is 2'b10 user and 2'b01 supervisor; 2'b00 and 2'b11 are kernel. The window 0xC0000000..0xDFFFFFFF is TLB-mapped for supervisor and kernel. The window from 0xE0000000 upward is TLB-mapped for kernel only. Any access to a window that the mode may not use is a bad address, and it requests no TLB lookup.
- R5: A bad address gives exception code 4 on a read and 5 on a write. TLB result 2'b01 (no match) or 2'b10 (invalid) gives code 2 on a read and 3 on a write. TLB result 2'b11 (modified) gives code 1. When there is no fault, the code is 0 and the fault flag is low. On a fault, the physical address is 0.
- R6: The refill output is high only for the no-match TLB result on a mapped access that the mode is allowed to make.
- R7: On the clock edge where fault is high, the bad-address register is loaded with the faulting address. Its reset value is 0.
- R8: On a faulting edge, context bits 22:4 take address bits 31:13 and context bits 3:0 become 0. Bits 31:23 keep their value, which is CTX_INIT[31:23] from reset.
- R9: On a faulting edge, entry-high bits 31:13 take address bits 31:13 and bits 12:8 become 0. Bits 7:0 keep their value, which is ASID_INIT from reset.
- R10: On an edge where fault is low, none of the three fault registers changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va | input | 32 | Virtual address of the access |
| is_write | input | 1 | 1 for a store, 0 for a load |
| mode | input | 2 | Privilege mode: 2'b10 user, 2'b01 supervisor, other kernel |
| err_lvl | input | 1 | Error-level flag |
| tlb_res | input | 2 | TLB result: 00 hit, 01 no match, 10 invalid, 11 modified |
| tlb_pa | input | 32 | Physical address returned by the TLB on a hit |
| tlb_req | output | 1 | High when the access is resolved through the TLB |
| pa | output | 32 | Physical address, 0 on a fault |
| fault | output | 1 | Access fails |
| exc_code | output | 5 | Exception code, 0 without a fault |
| refill | output | 1 | Fault is a TLB no-match |
| badaddr_q | output | 32 | Bad-address register |
| context_q | output | 32 | Context register |
| entryhi_q | output | 32 | Entry-high register |

## Verification
The address, tlb_req, fault, code and refill outputs are combinational. They are due in the same cycle as the inputs, so the bench drives on the falling edge and samples them one nanosecond later, before the next rising edge. The three fault registers change on the rising edge that follows a faulting cycle. The bench keeps its own copy of them, checks that copy at the next falling edge and only then advances it, so a register result is always compared one cycle after its stimulus. Directed cases cover each window boundary, each mode and each TLB result. Random cases then bias the top address bits to spread the accesses over all windows.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int VA_W   = 32;
    localparam int PG_SH  = 13;
    localparam int EC_W   = 5;
    localparam int VPN_W  = VA_W - PG_SH;

    typedef enum logic [2:0] {
        SG_USEG  = 3'd0,
        SG_KDIR0 = 3'd1,
        SG_KDIR1 = 3'd2,
        SG_SMAP  = 3'd3,
        SG_KMAP  = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        TR_HIT   = 2'b00,
        TR_MISS  = 2'b01,
        TR_INVAL = 2'b10,
        TR_MOD   = 2'b11
    } tlbres_e;

    localparam logic [EC_W-1:0] EC_NONE = 5'd0;
    localparam logic [EC_W-1:0] EC_MOD  = 5'd1;
    localparam logic [EC_W-1:0] EC_TLBL = 5'd2;
    localparam logic [EC_W-1:0] EC_TLBS = 5'd3;
    localparam logic [EC_W-1:0] EC_ADEL = 5'd4;
    localparam logic [EC_W-1:0] EC_ADES = 5'd5;

    localparam logic [VA_W-1:0] K0_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] K1_BASE = 32'hA000_0000;

    typedef struct packed {
        seg_e            seg;
        logic            ok;
        logic            mapped;
        logic [VA_W-1:0] dpa;
    } cls_t;

    typedef struct packed {
        logic            fault;
        logic            refill;
        logic [EC_W-1:0] code;
        logic [VA_W-1:0] pa;
    } res_t;

    function automatic logic md_user(input logic [1:0] m);
        return m == 2'b10;
    endfunction

    function automatic logic md_super(input logic [1:0] m);
        return m == 2'b01;
    endfunction

    function automatic logic md_kernel(input logic [1:0] m);
        return !md_user(m) && !md_super(m);
    endfunction

    function automatic seg_e seg_of(input logic [VA_W-1:0] a);
        seg_e s;
        case (a[VA_W-1 -: 3])
            3'b100:  s = SG_KDIR0;
            3'b101:  s = SG_KDIR1;
            3'b110:  s = SG_SMAP;
            3'b111:  s = SG_KMAP;
            default: s = SG_USEG;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_classify.sv
module seg_classify
    import seg_xlate_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      mode,
    input  logic            err_lvl,
    output cls_t            cls
);
    seg_e seg;
    logic kern;
    logic supv;

    always_comb begin
        seg  = seg_of(va);
        kern = md_kernel(mode);
        supv = md_super(mode);
        cls.seg    = seg;
        cls.ok     = 1'b0;
        cls.mapped = 1'b0;
        cls.dpa    = '0;
        case (seg)
            SG_USEG: begin
                cls.ok     = 1'b1;
                cls.mapped = !err_lvl;
                cls.dpa    = err_lvl ? va : '0;
            end
            SG_KDIR0: begin
                cls.ok  = kern;
                cls.dpa = va - K0_BASE;
            end
            SG_KDIR1: begin
                cls.ok  = kern;
                cls.dpa = va - K1_BASE;
            end
            SG_SMAP: begin
                cls.ok     = kern || supv;
                cls.mapped = 1'b1;
            end
            default: begin
                cls.ok     = kern;
                cls.mapped = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fault_encode.sv
module fault_encode
    import seg_xlate_pkg::*;
(
    input  cls_t            cls,
    input  logic            is_write,
    input  logic [1:0]      tlb_res,
    input  logic [VA_W-1:0] tlb_pa,
    output res_t            res
);
    tlbres_e tr;

    always_comb begin
        tr         = tlbres_e'(tlb_res);
        res.fault  = 1'b0;
        res.refill = 1'b0;
        res.code   = EC_NONE;
        res.pa     = '0;
        if (!cls.ok) begin
            res.fault = 1'b1;
            res.code  = is_write ? EC_ADES : EC_ADEL;
        end else if (!cls.mapped) begin
            res.pa = cls.dpa;
        end else begin
            case (tr)
                TR_HIT: res.pa = tlb_pa;
                TR_MISS: begin
                    res.fault  = 1'b1;
                    res.refill = 1'b1;
                    res.code   = is_write ? EC_TLBS : EC_TLBL;
                end
                TR_INVAL: begin
                    res.fault = 1'b1;
                    res.code  = is_write ? EC_TLBS : EC_TLBL;
                end
                default: begin
                    res.fault = 1'b1;
                    res.code  = EC_MOD;
                end
            endcase
        end
    end
endmodule

// File: rtl/fault_regs.sv
module fault_regs
    import seg_xlate_pkg::*;
#(
    parameter int              ASID_W    = 8,
    parameter logic [VA_W-1:0] CTX_INIT  = 32'h0,
    parameter logic [ASID_W-1:0] ASID_INIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fault,
    input  logic [VA_W-1:0] va,
    output logic [VA_W-1:0] bad_q,
    output logic [VA_W-1:0] ctx_q,
    output logic [VA_W-1:0] ehi_q
);
    localparam int CTX_LO  = 4;
    localparam int CTX_HI  = CTX_LO + VPN_W;
    localparam int EHI_GAP = PG_SH - ASID_W;

    logic [VA_W-1:0] ctx_d;
    logic [VA_W-1:0] ehi_d;

    always_comb begin
        ctx_d = {ctx_q[VA_W-1:CTX_HI], va[VA_W-1:PG_SH], {CTX_LO{1'b0}}};
        ehi_d = {va[VA_W-1:PG_SH], {EHI_GAP{1'b0}}, ehi_q[ASID_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q <= '0;
            ctx_q <= {CTX_INIT[VA_W-1:CTX_HI], {CTX_HI{1'b0}}};
            ehi_q <= {{(VA_W-ASID_W){1'b0}}, ASID_INIT};
        end else if (fault) begin
            bad_q <= va;
            ctx_q <= ctx_d;
            ehi_q <= ehi_d;
        end
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int                ASID_W    = 8,
    parameter logic [31:0]       CTX_INIT  = 32'hB680_0000,
    parameter logic [ASID_W-1:0] ASID_INIT = 8'h5A
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] va,
    input  logic        is_write,
    input  logic [1:0]  mode,
    input  logic        err_lvl,
    input  logic [1:0]  tlb_res,
    input  logic [31:0] tlb_pa,
    output logic        tlb_req,
    output logic [31:0] pa,
    output logic        fault,
    output logic [4:0]  exc_code,
    output logic        refill,
    output logic [31:0] badaddr_q,
    output logic [31:0] context_q,
    output logic [31:0] entryhi_q
);
    cls_t cls;
    res_t res;

    seg_classify u_cls (
        .va      (va),
        .mode    (mode),
        .err_lvl (err_lvl),
        .cls     (cls)
    );

    fault_encode u_enc (
        .cls      (cls),
        .is_write (is_write),
        .tlb_res  (tlb_res),
        .tlb_pa   (tlb_pa),
        .res      (res)
    );

    fault_regs #(
        .ASID_W    (ASID_W),
        .CTX_INIT  (CTX_INIT),
        .ASID_INIT (ASID_INIT)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .fault (res.fault),
        .va    (va),
        .bad_q (badaddr_q),
        .ctx_q (context_q),
        .ehi_q (entryhi_q)
    );

    assign tlb_req  = cls.ok && cls.mapped;
    assign pa       = res.pa;
    assign fault    = res.fault;
    assign exc_code = res.code;
    assign refill   = res.refill;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] va,
    input logic        is_write,
    input logic [1:0]  mode,
    input logic        tlb_req,
    input logic        fault,
    input logic [4:0]  exc_code,
    input logic        refill,
    input logic [31:0] badaddr_q,
    input logic [31:0] context_q,
    input logic [31:0] entryhi_q
);
    // R7
    badaddr_load_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> badaddr_q == $past(va));

    // R8
    context_load_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (context_q[31:23] == $past(context_q[31:23])) &&
                  (context_q[22:4] == $past(va[31:13])) && (context_q[3:0] == 4'd0));

    // R9
    entryhi_load_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> (entryhi_q[7:0] == $past(entryhi_q[7:0])) &&
                  (entryhi_q[31:13] == $past(va[31:13])) && (entryhi_q[12:8] == 5'd0));

    // R10
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |=> $stable(badaddr_q) && $stable(context_q) && $stable(entryhi_q));

    // R6
    refill_only_miss_chk: assert property (@(posedge clk) disable iff (rst)
        refill |-> fault && tlb_req && (exc_code == 5'd2 || exc_code == 5'd3));

    // R4
    user_kernel_space_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && va[31]) |-> fault && !tlb_req &&
                                      (exc_code == (is_write ? 5'd5 : 5'd4)));

    // R5
    no_fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |-> exc_code == 5'd0);
endmodule

bind seg_xlate_top seg_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .va        (va),
    .is_write  (is_write),
    .mode      (mode),
    .tlb_req   (tlb_req),
    .fault     (fault),
    .exc_code  (exc_code),
    .refill    (refill),
    .badaddr_q (badaddr_q),
    .context_q (context_q),
    .entryhi_q (entryhi_q)
);

// File: tb/sim_seg_xlate_top.sv
`timescale 1ns/1ps
module sim_seg_xlate_top;
    localparam logic [31:0] CTXI  = 32'hB680_0000;
    localparam logic [7:0]  ASIDI = 8'h5A;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] va;
    logic        is_write;
    logic [1:0]  mode;
    logic        err_lvl;
    logic [1:0]  tlb_res;
    logic [31:0] tlb_pa;
    logic        tlb_req;
    logic [31:0] pa;
    logic        fault;
    logic [4:0]  exc_code;
    logic        refill;
    logic [31:0] badaddr_q, context_q, entryhi_q;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m_bad, m_ctx, m_ehi;

    always #2 clk = ~clk;

    seg_xlate_top #(.CTX_INIT(CTXI), .ASID_INIT(ASIDI)) u0 (
        .clk(clk), .rst(rst), .va(va), .is_write(is_write), .mode(mode),
        .err_lvl(err_lvl), .tlb_res(tlb_res), .tlb_pa(tlb_pa), .tlb_req(tlb_req),
        .pa(pa), .fault(fault), .exc_code(exc_code), .refill(refill),
        .badaddr_q(badaddr_q), .context_q(context_q), .entryhi_q(entryhi_q)
    );

    typedef struct packed {
        logic        req;
        logic        flt;
        logic        rfl;
        logic [4:0]  code;
        logic [31:0] pa;
    } exp_t;

    function automatic exp_t model(input logic [31:0] a, input logic wr, input logic [1:0] m,
                                   input logic el, input logic [1:0] tr, input logic [31:0] tp);
        exp_t e;
        logic usr, sup, krn, bad, mapd;
        usr = (m == 2'b10);
        sup = (m == 2'b01);
        krn = !usr && !sup;
        bad = 1'b0; mapd = 1'b0;
        e = '0;
        if (a < 32'h8000_0000) begin
            if (el) e.pa = a; else mapd = 1'b1;
        end else if (a < 32'hA000_0000) begin
            if (krn) e.pa = a - 32'h8000_0000; else bad = 1'b1;
        end else if (a < 32'hC000_0000) begin
            if (krn) e.pa = a - 32'hA000_0000; else bad = 1'b1;
        end else if (a < 32'hE000_0000) begin
            if (krn || sup) mapd = 1'b1; else bad = 1'b1;
        end else begin
            if (krn) mapd = 1'b1; else bad = 1'b1;
        end
        if (bad) begin
            e.flt = 1'b1; e.code = wr ? 5'd5 : 5'd4;
        end else if (mapd) begin
            e.req = 1'b1;
            case (tr)
                2'b00: e.pa = tp;
                2'b01: begin e.flt = 1'b1; e.rfl = 1'b1; e.code = wr ? 5'd3 : 5'd2; end
                2'b10: begin e.flt = 1'b1; e.code = wr ? 5'd3 : 5'd2; end
                default: begin e.flt = 1'b1; e.code = 5'd1; end
            endcase
        end
        return e;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(req, "badaddr", badaddr_q, m_bad);
        chk(req, "context", context_q, m_ctx);
        chk(req, "entryhi", entryhi_q, m_ehi);
    endtask

    // One access: drive at the falling edge, check outputs 1 ns later, advance register model.
    task automatic access(input string req, input logic [31:0] a, input logic wr,
                          input logic [1:0] m, input logic el, input logic [1:0] tr,
                          input logic [31:0] tp);
        exp_t e;
        @(negedge clk);
        check_regs("R10");
        va = a; is_write = wr; mode = m; err_lvl = el; tlb_res = tr; tlb_pa = tp;
        #1;
        e = model(a, wr, m, el, tr, tp);
        chk(req, "tlb_req", {31'd0, tlb_req}, {31'd0, e.req});
        chk(req, "fault", {31'd0, fault}, {31'd0, e.flt});
        chk(req, "exc_code", {27'd0, exc_code}, {27'd0, e.code});
        chk(req, "refill", {31'd0, refill}, {31'd0, e.rfl});
        chk(req, "pa", pa, e.pa);
        if (e.flt) begin
            m_bad = a;
            m_ctx = {m_ctx[31:23], a[31:13], 4'd0};
            m_ehi = {a[31:13], 5'd0, m_ehi[7:0]};
        end
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; va = '0; is_write = 1'b0; mode = 2'b00; err_lvl = 1'b1;
        tlb_res = 2'b00; tlb_pa = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_bad = '0;
        m_ctx = {CTXI[31:23], 23'd0};
        m_ehi = {24'd0, ASIDI};
        // R7 R8 R9 reset state
        check_regs("R7");

        // R1 direct user window, any mode
        access("R1", 32'h1234_5678, 1'b0, 2'b10, 1'b1, 2'b01, 32'hFFFF_FFFF);
        access("R1", 32'h7FFF_FFFF, 1'b1, 2'b01, 1'b1, 2'b11, 32'h0);
        // R2 mapped user window
        access("R2", 32'h0040_2000, 1'b0, 2'b10, 1'b0, 2'b00, 32'h0ABC_D123);
        access("R2", 32'h0040_2000, 1'b1, 2'b10, 1'b0, 2'b01, 32'h0);
        // R3 direct kernel windows, boundaries, tlb_res ignored
        access("R3", 32'h8000_0000, 1'b0, 2'b00, 1'b0, 2'b01, 32'h0);
        access("R3", 32'h9FFF_FFFF, 1'b1, 2'b11, 1'b0, 2'b11, 32'h0);
        access("R3", 32'hA000_0000, 1'b0, 2'b00, 1'b0, 2'b10, 32'h0);
        access("R3", 32'hBFFF_F004, 1'b0, 2'b11, 1'b0, 2'b01, 32'h0);
        // R4 privilege checks
        access("R4", 32'h8000_1000, 1'b0, 2'b10, 1'b1, 2'b00, 32'h0);
        access("R4", 32'hA123_4000, 1'b1, 2'b01, 1'b0, 2'b00, 32'h0);
        access("R4", 32'hC000_0000, 1'b0, 2'b01, 1'b0, 2'b00, 32'h1111_2222);
        access("R4", 32'hDFFF_FFFF, 1'b1, 2'b10, 1'b0, 2'b00, 32'h0);
        access("R4", 32'hE000_0000, 1'b0, 2'b01, 1'b0, 2'b00, 32'h0);
        access("R4", 32'hFFFF_E000, 1'b0, 2'b00, 1'b0, 2'b00, 32'h3333_4444);
        // R5 R6 TLB result codes
        access("R5", 32'hC800_6000, 1'b0, 2'b00, 1'b0, 2'b10, 32'h0);
        access("R5", 32'hC800_6000, 1'b1, 2'b00, 1'b0, 2'b10, 32'h0);
        access("R5", 32'hE555_A000, 1'b1, 2'b00, 1'b0, 2'b11, 32'h0);
        access("R6", 32'hD000_2000, 1'b0, 2'b01, 1'b0, 2'b01, 32'h0);
        // R8 R9 fault with all-ones address bits
        access("R8", 32'hFFFF_FFFF, 1'b1, 2'b10, 1'b0, 2'b00, 32'h0);
        access("R9", 32'h0000_1FFF, 1'b0, 2'b10, 1'b0, 2'b01, 32'h0);
        // R10 non-faulting accesses after a fault
        access("R10", 32'h8765_4321, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            a = $urandom;
            a[31:29] = 3'($urandom_range(0, 7));
            access("R5", a, 1'($urandom), 2'($urandom), 1'($urandom),
                   2'($urandom), $urandom);
        end

        @(negedge clk);
        check_regs("R10");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule